// File: doc/BRIEF.md
# Tone Detect Guard Time Qualifier

This block sits behind a dual-tone detector and turns its raw "both tones present" flag into a qualified alert. The alert rises only after the raw flag has held high for a present guard time. It falls only after the raw flag has held low for a separate absent guard time. Short bursts and short dropouts therefore do not reach the alert output. A single saturating counter plays the role of the guard capacitor. It counts up toward the present threshold while the alert is low and down from the absent threshold while the alert is high. Each time the alert changes, the counter is reloaded at once to the start of the opposite transition.

The path works only while the FSK-enable input is low, and only after an enable delay counted from that input falling. A sleep input forces the alert low and the counter idle. It also restarts the enable delay. All times are counted in `tick_i` pulses, which are one-millisecond enables derived from the system clock. The block also passes out the gated raw flag with no guard applied.

Top module: `tone_guard_qual`

## Requirements
- R1: While `rst_ni` is low and after it is released, `alert_o` and `raw_det_o` are low and the guard counter is idle (zero).
- R2: `raw_det_o` is low while `fsk_en_i` or `sleep_i` is high. After `fsk_en_i` falls, with sleep low, it also stays low until ENABLE_TICKS ticks have been counted; the path is open from the edge of the last of those ticks.
- R3: Once the path is open, `raw_det_o` equals `raw_det_i` in the same cycle, with no guard applied.
- R4: With `alert_o` low, `alert_o` rises on the clock edge of the PRESENT_TICKS-th consecutive tick sampled with `raw_det_o` high. Without a tick, `alert_o` does not change except through sleep.
- R5: With `alert_o` high, `alert_o` falls on the clock edge of the ABSENT_TICKS-th consecutive tick sampled with `raw_det_o` low.
- R6: Any single clock edge with `raw_det_o` low while `alert_o` is low restarts the present count from zero. A burst shorter than PRESENT_TICKS ticks never raises `alert_o`.
- R7: Any single clock edge with `raw_det_o` high while `alert_o` is high reloads the absent count. A dropout shorter than ABSENT_TICKS ticks never drops `alert_o`.
- R8: On every change of `alert_o`, the counter is loaded with the starting value for the opposite transition. An immediate reversal therefore needs its full guard time. PRESENT_TICKS and ABSENT_TICKS are independent parameters (each at least 1).
- R9: `sleep_i` high forces `alert_o` low on the next clock edge, holds the counter idle and clears the enable delay. After sleep is released, the full enable delay and the present guard time apply again.
- R10: Raising `fsk_en_i` while `alert_o` is high closes the path, so `alert_o` falls after ABSENT_TICKS further ticks.
- R11: The counter never exceeds the larger of the two thresholds and never wraps, however long the input stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-base enable, one per guard unit |
| raw_det_i | input | 1 | Raw dual-tone present flag from the detector |
| fsk_en_i | input | 1 | High selects FSK reception and disables this path |
| sleep_i | input | 1 | Sleep override, forces idle |
| raw_det_o | output | 1 | Gated raw flag, no guard time |
| alert_o | output | 1 | Guard-qualified alert |

## Verification
The assertions take all inputs to be synchronous to `clk_i` and `tick_i` to be a single-cycle pulse. The edge-cause checks rely on this when they relate an alert change to the tick and raw flag of the previous cycle. The stimulus changes every input on the falling clock edge. It builds each tick as a one-cycle pulse followed by idle cycles, so no tick is ever held across two edges. Glitch cases, such as a one-cycle dropout, are placed on non-tick cycles. This shows that the restart does not wait for a tick.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [0:0] {
    GUARD_IDLE  = 1'b0,
    GUARD_ALERT = 1'b1
  } guard_state_e;

  function automatic int unsigned cnt_w(input int unsigned max_v);
    return (max_v < 2) ? 1 : $clog2(max_v + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tg_enable_timer.sv
module tg_enable_timer #(
  parameter int unsigned ENABLE_TICKS = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fsk_en_i,
  input  logic sleep_i,
  output logic path_on_o
);

  logic blocked;
  assign blocked = fsk_en_i | sleep_i;

  generate
    if (ENABLE_TICKS == 0) begin : g_no_delay
      assign path_on_o = !blocked;
    end else begin : g_delay
      localparam int unsigned W = tg_pkg::cnt_w(ENABLE_TICKS);
      localparam logic [W-1:0] LIMIT = W'(ENABLE_TICKS);
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      cnt_q <= '0;
        else if (blocked)                 cnt_q <= '0;
        else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end

      assign path_on_o = (cnt_q == LIMIT) && !blocked;
    end
  endgenerate

endmodule

// File: rtl/tg_guard_integrator.sv
module tg_guard_integrator #(
  parameter int unsigned PRESENT_TICKS = 40,
  parameter int unsigned ABSENT_TICKS  = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic det_i,
  input  logic sleep_i,
  output logic alert_o
);
  import tg_pkg::*;

  localparam int unsigned MAXV = max2(PRESENT_TICKS, ABSENT_TICKS);
  localparam int unsigned W    = cnt_w(MAXV);
  localparam logic [W-1:0] P_LAST = W'(PRESENT_TICKS - 1);
  localparam logic [W-1:0] A_LOAD = W'(ABSENT_TICKS);
  localparam logic [W-1:0] ONE    = W'(1);

  guard_state_e state_q, state_d;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (sleep_i) begin
      state_d = GUARD_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        GUARD_IDLE: begin
          if (!det_i) begin
            cnt_d = '0;                 // dropout restarts present count
          end else if (tick_i) begin
            if (cnt_q >= P_LAST) begin
              state_d = GUARD_ALERT;
              cnt_d   = A_LOAD;         // fast load for absent guard
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        GUARD_ALERT: begin
          if (det_i) begin
            cnt_d = A_LOAD;             // tone back, reload absent guard
          end else if (tick_i) begin
            if (cnt_q <= ONE) begin
              state_d = GUARD_IDLE;
              cnt_d   = '0;             // fast reset for present guard
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: begin
          state_d = GUARD_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GUARD_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign alert_o = (state_q == GUARD_ALERT);

endmodule

// File: rtl/tone_guard_qual.sv
module tone_guard_qual #(
  parameter int unsigned ENABLE_TICKS  = 25,
  parameter int unsigned PRESENT_TICKS = 40,
  parameter int unsigned ABSENT_TICKS  = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_det_i,
  input  logic fsk_en_i,
  input  logic sleep_i,
  output logic raw_det_o,
  output logic alert_o
);

  logic path_on;
  logic det_gated;

  tg_enable_timer #(
    .ENABLE_TICKS(ENABLE_TICKS)
  ) u_enable (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .fsk_en_i (fsk_en_i),
    .sleep_i  (sleep_i),
    .path_on_o(path_on)
  );

  assign det_gated = raw_det_i & path_on;

  tg_guard_integrator #(
    .PRESENT_TICKS(PRESENT_TICKS),
    .ABSENT_TICKS (ABSENT_TICKS)
  ) u_integ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .det_i  (det_gated),
    .sleep_i(sleep_i),
    .alert_o(alert_o)
  );

  assign raw_det_o = det_gated;

endmodule

// File: rtl/tg_guard_checker.sv
module tg_guard_checker #(
  parameter int unsigned PRESENT_TICKS = 40,
  parameter int unsigned ABSENT_TICKS  = 30,
  localparam int unsigned MAXV = tg_pkg::max2(PRESENT_TICKS, ABSENT_TICKS),
  localparam int unsigned W    = tg_pkg::cnt_w(MAXV)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         raw_det_i,
  input logic         fsk_en_i,
  input logic         sleep_i,
  input logic         raw_det_o,
  input logic         alert_o,
  input logic [W-1:0] guard_cnt_i
);

  localparam logic [W-1:0] MAX_CNT = W'(MAXV);
  localparam logic [W-1:0] A_LOAD  = W'(ABSENT_TICKS);

  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsk_en_i || sleep_i) |-> !raw_det_o);

  p_echo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_det_o |-> raw_det_i);

  p_rise_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_o) |-> $past(raw_det_o && tick_i && !sleep_i));

  p_hold_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !sleep_i) |=> $stable(alert_o));

  p_fall_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alert_o) |-> $past(sleep_i || (tick_i && !raw_det_o)));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_o && !raw_det_o) |=> (guard_cnt_i == '0));

  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_o && raw_det_o && !sleep_i) |=> (alert_o && guard_cnt_i == A_LOAD));

  p_sleep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!alert_o && guard_cnt_i == '0));

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guard_cnt_i <= MAX_CNT);

endmodule

bind tone_guard_qual tg_guard_checker #(
  .PRESENT_TICKS(PRESENT_TICKS),
  .ABSENT_TICKS (ABSENT_TICKS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .raw_det_i  (raw_det_i),
  .fsk_en_i   (fsk_en_i),
  .sleep_i    (sleep_i),
  .raw_det_o  (raw_det_o),
  .alert_o    (alert_o),
  .guard_cnt_i(u_integ.cnt_q)
);

// File: tb/sim_tone_guard_qual.sv
module sim_tone_guard_qual;

  localparam int unsigned E = 6;
  localparam int unsigned P = 5;
  localparam int unsigned A = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic raw = 1'b0;
  logic fsk_en = 1'b1;
  logic sleep = 1'b0;
  logic raw_det_o, alert_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tone_guard_qual #(
    .ENABLE_TICKS (E),
    .PRESENT_TICKS(P),
    .ABSENT_TICKS (A)
  ) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .raw_det_i(raw),
    .fsk_en_i (fsk_en),
    .sleep_i  (sleep),
    .raw_det_o(raw_det_o),
    .alert_o  (alert_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic drive_raw(input logic v);
    @(negedge clk) raw = v;
    #1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 alert in reset", alert_o, 1'b0);
    chk("R1 raw in reset", raw_det_o, 1'b0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 alert after reset", alert_o, 1'b0);
  endtask

  task automatic t_enable;
    drive_raw(1'b1);
    tick_n(2);
    chk("R2 blocked by fsk_en", raw_det_o, 1'b0);
    @(negedge clk) fsk_en = 1'b0;
    tick_n(E - 1);
    chk("R2 inside enable delay", raw_det_o, 1'b0);
    chk("R2 no alert during delay", alert_o, 1'b0);
    tick_n(1);
    chk("R2 path open", raw_det_o, 1'b1);
    drive_raw(1'b0);
    chk("R3 echo low", raw_det_o, 1'b0);
    drive_raw(1'b1);
    chk("R3 echo high", raw_det_o, 1'b1);
  endtask

  task automatic t_present;
    tick_n(P - 1);
    chk("R4 before present guard", alert_o, 1'b0);
    tick_n(1);
    chk("R4 after present guard", alert_o, 1'b1);
  endtask

  task automatic t_dropout;
    drive_raw(1'b0);
    tick_n(A - 1);
    chk("R8 full absent guard after rise", alert_o, 1'b1);
    drive_raw(1'b1);
    drive_raw(1'b0);
    tick_n(A - 1);
    chk("R7 short dropout held", alert_o, 1'b1);
    tick_n(1);
    chk("R5 fall after absent guard", alert_o, 1'b0);
  endtask

  task automatic t_burst;
    drive_raw(1'b1);
    tick_n(P - 1);
    chk("R8 full present guard after fall", alert_o, 1'b0);
    drive_raw(1'b0);
    drive_raw(1'b1);
    tick_n(P - 1);
    chk("R6 burst after glitch not enough", alert_o, 1'b0);
    tick_n(1);
    chk("R6 full burst qualifies", alert_o, 1'b1);
  endtask

  task automatic t_saturate;
    tick_n(3 * P);
    chk("R11 long present holds", alert_o, 1'b1);
    drive_raw(1'b0);
    tick_n(A);
    chk("R11 fall after long present", alert_o, 1'b0);
    tick_n(3 * A);
    chk("R11 long absent holds", alert_o, 1'b0);
    drive_raw(1'b1);
    tick_n(P - 1);
    chk("R11 no wrap before rise", alert_o, 1'b0);
    tick_n(1);
    chk("R11 rise after long absent", alert_o, 1'b1);
  endtask

  task automatic t_sleep;
    @(negedge clk) sleep = 1'b1;
    #1 chk("R9 raw gated in sleep", raw_det_o, 1'b0);
    @(negedge clk);
    chk("R9 alert forced low", alert_o, 1'b0);
    tick_n(4);
    chk("R9 alert stays low in sleep", alert_o, 1'b0);
    @(negedge clk) sleep = 1'b0;
    tick_n(E - 1);
    chk("R9 enable delay restarted", raw_det_o, 1'b0);
    tick_n(1);
    chk("R9 path reopened", raw_det_o, 1'b1);
    tick_n(P - 1);
    chk("R9 present guard from idle", alert_o, 1'b0);
    tick_n(1);
    chk("R9 alert after wake", alert_o, 1'b1);
  endtask

  task automatic t_fsk;
    @(negedge clk) fsk_en = 1'b1;
    #1 chk("R10 path closed", raw_det_o, 1'b0);
    tick_n(A - 1);
    chk("R10 alert held in guard", alert_o, 1'b1);
    tick_n(1);
    chk("R10 alert decays", alert_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_present();
    t_dropout();
    t_burst();
    t_saturate();
    t_sleep();
    t_fsk();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule